// File: doc/BRIEF.md
# Periodic Thermal Sensor Sampling Scheduler

This block decides when each of up to three temperature sensor channels is sampled and turns the converted codes into per-channel readings. A period timer, counted in blocks of a fixed number of module clocks scaled by a programmable multiplier, starts a measurement round. In each round the enabled channels are visited from the lowest index upwards. For each channel the block holds an acquire window of a programmable length, then asks an external converter for a result and waits for its completion handshake.

Each channel has its own accumulator. With the averaging filter off, every converted 12-bit code goes straight to that channel's reading. With the filter on, the block collects a power-of-two number of codes and then publishes their truncated mean. Every published reading comes with a one-cycle ready pulse for that channel. Clearing all channel enables stops the scheduler and discards the partial sums.

Top module: `thermal_sample_sched`

## Requirements
- R1: While reset is asserted and just after it, `data_out`, `data_rdy`, `adc_sample` and `adc_start` are all zero.
- R2: Each acquire window holds `adc_sample` high for exactly `cfg_acq_len`+1 cycles. `adc_start` is a single-cycle pulse in the cycle right after the window.
- R3: When a round fits inside the period, consecutive rounds start exactly `UNIT_CYC`×(`cfg_period`+1) cycles apart.
- R4: Within a round, channels are converted in ascending index order. A channel whose bit in `cfg_ch_en` (bit c enables channel c) is clear is never sampled.
- R5: If a period boundary arrives while a round is still running, the next round begins after the current round ends. Several such boundaries merge into one pending round, and `adc_start` is never issued while a conversion is outstanding.
- R6: With `cfg_filter[2]`=0, every completed conversion updates its channel's reading, and `data_rdy[c]` pulses one cycle after the `adc_done` cycle.
- R7: With `cfg_filter[2]`=1 and type t=`cfg_filter[1:0]`, a reading is published after 2^(t+1) codes. Its value is the sum shifted right by t+1, with the fraction dropped (0x5 averages 4 codes, 0x6 averages 8).
- R8: `data_rdy` has at most one bit set. `data_out` changes only in a cycle where `data_rdy` is non-zero.
- R9: When all enable bits are zero, the scheduler stops within one cycle and the period timer and every partial accumulator return to zero. A later average therefore uses only codes taken after re-enabling.
- R10: The reading of channel c sits right-justified in `data_out[c*12 +: 12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_acq_len | input | ACQ_W | Acquire window length minus one |
| cfg_period | input | PER_W | Period multiplier minus one |
| cfg_ch_en | input | NUM_CH | Per-channel enable, bit c for channel c |
| cfg_filter | input | 3 | Bit 2 filter on, bits 1:0 averaging type |
| adc_sample | output | 1 | High during the acquire window |
| adc_start | output | 1 | One-cycle conversion request |
| adc_ch | output | CH_W | Channel being acquired or converted |
| adc_done | input | 1 | One-cycle conversion completion |
| adc_code | input | DATA_W | Converted code, valid with `adc_done` |
| data_out | output | NUM_CH*DATA_W | Per-channel readings |
| data_rdy | output | NUM_CH | Per-channel one-cycle update pulse |

## Verification
The checker assumes that the converter answers each `adc_start` with exactly one `adc_done` pulse, no earlier than the next cycle, and never raises `adc_done` otherwise. It also assumes that the acquire length, period and filter setting stay fixed while any channel is enabled; only a full clear of the enables may interrupt a round. The bench's converter model keeps to this with a fixed reply latency after each request and drops any pending reply when the bench clears the enables. The bench changes configuration only while all enables are zero.

// File: rtl/tss_pkg.sv
package tss_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACQ  = 2'd1,
        SEQ_REQ  = 2'd2,
        SEQ_WAIT = 2'd3
    } seq_state_e;

    localparam int FILT_EN_BIT = 2;
    localparam int FILT_TYPE_W = 2;
endpackage

// File: rtl/tss_period_timer.sv
module tss_period_timer #(
    parameter int UNIT_CYC = 4096,
    parameter int PER_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] per_sel,
    output logic             tick
);
    localparam int UW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
    localparam logic [UW-1:0] UNIT_LAST = UW'(UNIT_CYC - 1);

    typedef struct packed {
        logic [UW-1:0]    unit;
        logic [PER_W-1:0] mult;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        tick = 1'b0;
        if (!run) begin
            t_d = '0;
        end else if (t_q.unit == UNIT_LAST) begin
            t_d.unit = '0;
            if (t_q.mult >= per_sel) begin
                t_d.mult = '0;
                tick     = 1'b1;
            end else begin
                t_d.mult = t_q.mult + 1'b1;
            end
        end else begin
            t_d.unit = t_q.unit + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/tss_conv_seq.sv
module tss_conv_seq
    import tss_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CH_W   = 2,
    parameter int ACQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic              tick,
    input  logic [ACQ_W-1:0]  acq_len,
    input  logic              adc_done,
    output logic              sample_o,
    output logic              start_o,
    output logic [CH_W-1:0]   ch_o,
    output logic              cap_o
);
    typedef struct packed {
        seq_state_e       state;
        logic [CH_W-1:0]  ch;
        logic [ACQ_W-1:0] cnt;
        logic             pend;
    } seq_t;

    seq_t s_d, s_q;

    // lowest enabled channel at or above 'from'; MSB flags a hit
    function automatic logic [CH_W:0] pick(input logic [NUM_CH-1:0] en, input int from);
        logic [CH_W:0] r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (en[i] && (i >= from)) r = {1'b1, CH_W'(i)};
        end
        return r;
    endfunction

    logic [CH_W:0] first_hit, next_hit;
    logic          advance;

    always_comb begin
        s_d       = s_q;
        start_o   = 1'b0;
        cap_o     = 1'b0;
        advance   = 1'b0;
        first_hit = pick(ch_en, 0);
        next_hit  = pick(ch_en, int'(s_q.ch) + 1);

        unique case (s_q.state)
            SEQ_IDLE: begin
                if (s_q.pend) begin
                    s_d.pend = 1'b0;
                    if (first_hit[CH_W]) begin
                        s_d.state = SEQ_ACQ;
                        s_d.ch    = first_hit[CH_W-1:0];
                        s_d.cnt   = '0;
                    end
                end
            end
            SEQ_ACQ: begin
                if (s_q.cnt == acq_len) s_d.state = SEQ_REQ;
                else                    s_d.cnt   = s_q.cnt + 1'b1;
            end
            SEQ_REQ: begin
                if (ch_en[s_q.ch]) begin
                    start_o   = 1'b1;
                    s_d.state = SEQ_WAIT;
                end else begin
                    advance = 1'b1;
                end
            end
            SEQ_WAIT: begin
                if (adc_done) begin
                    cap_o   = 1'b1;
                    advance = 1'b1;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase

        if (advance) begin
            if (next_hit[CH_W]) begin
                s_d.state = SEQ_ACQ;
                s_d.ch    = next_hit[CH_W-1:0];
                s_d.cnt   = '0;
            end else begin
                s_d.state = SEQ_IDLE;
            end
        end

        if (tick) s_d.pend = 1'b1;

        if (ch_en == '0) begin
            s_d     = '0;
            start_o = 1'b0;
            cap_o   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sample_o = (s_q.state == SEQ_ACQ);
    assign ch_o     = s_q.ch;
endmodule

// File: rtl/tss_avg_lane.sv
module tss_avg_lane
    import tss_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   cap,
    input  logic [DATA_W-1:0]      code,
    input  logic                   filt_en,
    input  logic [FILT_TYPE_W-1:0] filt_type,
    output logic [DATA_W-1:0]      data_o,
    output logic                   rdy_o
);
    localparam int MAX_LOG = 1 << FILT_TYPE_W;
    localparam int SUM_W   = DATA_W + MAX_LOG;
    localparam int CNT_W   = MAX_LOG + 1;

    typedef struct packed {
        logic [SUM_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic              rdy;
    } lane_t;

    lane_t l_d, l_q;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] shifted;
    logic [CNT_W-1:0] n_next;
    logic [CNT_W-1:0] target;
    int               shamt;

    always_comb begin
        l_d     = l_q;
        l_d.rdy = 1'b0;
        shamt   = int'(filt_type) + 1;
        sum     = l_q.acc + SUM_W'(code);
        n_next  = l_q.cnt + 1'b1;
        target  = CNT_W'(1) << shamt;
        shifted = sum >> shamt;

        if (clr) begin
            l_d.acc = '0;
            l_d.cnt = '0;
        end else if (cap) begin
            if (!filt_en) begin
                l_d.data = code;
                l_d.rdy  = 1'b1;
            end else if (n_next >= target) begin
                l_d.data = shifted[DATA_W-1:0];
                l_d.acc  = '0;
                l_d.cnt  = '0;
                l_d.rdy  = 1'b1;
            end else begin
                l_d.acc = sum;
                l_d.cnt = n_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign data_o = l_q.data;
    assign rdy_o  = l_q.rdy;
endmodule

// File: rtl/thermal_sample_sched.sv
module thermal_sample_sched
    import tss_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int DATA_W   = 12,
    parameter int ACQ_W    = 16,
    parameter int PER_W    = 12,
    parameter int UNIT_CYC = 4096,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ACQ_W-1:0]         cfg_acq_len,
    input  logic [PER_W-1:0]         cfg_period,
    input  logic [NUM_CH-1:0]        cfg_ch_en,
    input  logic [2:0]               cfg_filter,
    output logic                     adc_sample,
    output logic                     adc_start,
    output logic [CH_W-1:0]          adc_ch,
    input  logic                     adc_done,
    input  logic [DATA_W-1:0]        adc_code,
    output logic [NUM_CH*DATA_W-1:0] data_out,
    output logic [NUM_CH-1:0]        data_rdy
);
    logic any_en;
    logic tick;
    logic cap;

    assign any_en = (cfg_ch_en != '0);

    tss_period_timer #(
        .UNIT_CYC(UNIT_CYC),
        .PER_W   (PER_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (any_en),
        .per_sel(cfg_period),
        .tick   (tick)
    );

    tss_conv_seq #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W),
        .ACQ_W (ACQ_W)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ch_en   (cfg_ch_en),
        .tick    (tick),
        .acq_len (cfg_acq_len),
        .adc_done(adc_done),
        .sample_o(adc_sample),
        .start_o (adc_start),
        .ch_o    (adc_ch),
        .cap_o   (cap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        logic [DATA_W-1:0] lane_data;
        logic              lane_rdy;

        tss_avg_lane #(
            .DATA_W(DATA_W)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (!any_en),
            .cap      (cap && (adc_ch == CH_W'(c))),
            .code     (adc_code),
            .filt_en  (cfg_filter[FILT_EN_BIT]),
            .filt_type(cfg_filter[FILT_TYPE_W-1:0]),
            .data_o   (lane_data),
            .rdy_o    (lane_rdy)
        );

        assign data_out[c*DATA_W +: DATA_W] = lane_data;
        assign data_rdy[c]                  = lane_rdy;
    end
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 12,
    parameter int ACQ_W  = 16,
    parameter int CH_W   = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ACQ_W-1:0]         cfg_acq_len,
    input logic [NUM_CH-1:0]        cfg_ch_en,
    input logic                     adc_sample,
    input logic                     adc_start,
    input logic [CH_W-1:0]          adc_ch,
    input logic                     adc_done,
    input logic [NUM_CH*DATA_W-1:0] data_out,
    input logic [NUM_CH-1:0]        data_rdy
);
    logic [ACQ_W:0] hi_cnt;
    logic           outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          hi_cnt <= '0;
        else if (adc_sample) hi_cnt <= hi_cnt + 1'b1;
        else                 hi_cnt <= '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                               outst_q <= 1'b0;
        else if (cfg_ch_en == '0 || adc_done)     outst_q <= 1'b0;
        else if (adc_start)                       outst_q <= 1'b1;
    end

    assert_acq_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_sample) && $past(cfg_ch_en) != '0 && cfg_ch_en != '0)
            |-> (hi_cnt == {1'b0, cfg_acq_len} + 1'b1));

    assert_start_after_acq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> ($past(adc_sample) && !adc_sample));

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    assert_start_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> cfg_ch_en[adc_ch]);

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !outst_q);

    assert_rdy_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy != '0) |-> $past(adc_done));

    assert_rdy_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_rdy));

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> (data_rdy != '0));

    assert_clear_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ch_en == '0) |=> (!adc_sample && !adc_start));
endmodule

bind thermal_sample_sched tss_checker #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W),
    .ACQ_W (ACQ_W),
    .CH_W  (CH_W)
) i_tss_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_acq_len(cfg_acq_len),
    .cfg_ch_en  (cfg_ch_en),
    .adc_sample (adc_sample),
    .adc_start  (adc_start),
    .adc_ch     (adc_ch),
    .adc_done   (adc_done),
    .data_out   (data_out),
    .data_rdy   (data_rdy)
);

// File: tb/test_thermal_sample_sched.sv
module test_thermal_sample_sched;
    localparam int NUM_CH = 3;
    localparam int DATA_W = 12;
    localparam int ACQ_W  = 16;
    localparam int PER_W  = 12;
    localparam int UNIT   = 64;

    // {enable[2:0], filter[2:0], acq[7:0], period[3:0]}
    localparam logic [17:0] VEC [0:5] = '{
        {3'b111, 3'b000, 8'd3,  4'd1},
        {3'b101, 3'b101, 8'd7,  4'd0},
        {3'b010, 3'b110, 8'd2,  4'd1},
        {3'b110, 3'b100, 8'd5,  4'd0},
        {3'b011, 3'b111, 8'd1,  4'd0},
        {3'b001, 3'b110, 8'd15, 4'd2}
    };

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [ACQ_W-1:0]         cfg_acq_len = '0;
    logic [PER_W-1:0]         cfg_period = '0;
    logic [NUM_CH-1:0]        cfg_ch_en = '0;
    logic [2:0]               cfg_filter = '0;
    logic                     adc_sample, adc_start;
    logic [1:0]               adc_ch;
    logic                     adc_done = 1'b0;
    logic [DATA_W-1:0]        adc_code = '0;
    logic [NUM_CH*DATA_W-1:0] data_out;
    logic [NUM_CH-1:0]        data_rdy;

    thermal_sample_sched #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ACQ_W(ACQ_W),
        .PER_W(PER_W), .UNIT_CYC(UNIT)
    ) i_thermal_sample_sched (
        .clk(clk), .rst_n(rst_n), .cfg_acq_len(cfg_acq_len),
        .cfg_period(cfg_period), .cfg_ch_en(cfg_ch_en), .cfg_filter(cfg_filter),
        .adc_sample(adc_sample), .adc_start(adc_start), .adc_ch(adc_ch),
        .adc_done(adc_done), .adc_code(adc_code),
        .data_out(data_out), .data_rdy(data_rdy)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // converter model and monitor state
    bit          mdl_clear = 1'b0;
    int          mdl_dly = 3;
    bit          busy = 1'b0;
    int          dly = 0;
    int          ch_l = 0;
    int          kcnt [NUM_CH];
    int          rdy_cnt [NUM_CH];
    logic [11:0] rdy_first [NUM_CH];
    int          seq_log [64];
    longint      start_cyc [64];
    int          nstart = 0;
    int          hi = 0;
    int          last_hi = 0;
    int          overlap_err = 0;
    longint      cyc = 0;

    function automatic int gen(input int ch, input int k);
        return (ch * 700 + k * 151 + 9) % 4096;
    endfunction

    function automatic int exp_avg(input int ch, input int n);
        int s;
        s = 0;
        for (int k = 0; k < n; k++) s += gen(ch, k);
        return s / n;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        for (int c = 0; c < NUM_CH; c++) begin
            kcnt[c] = 0; rdy_cnt[c] = 0; rdy_first[c] = '0;
        end
        forever begin
            @(negedge clk);
            cyc++;
            adc_done = 1'b0;
            if (mdl_clear) begin
                busy = 1'b0; nstart = 0; overlap_err = 0; last_hi = 0; hi = 0;
                for (int c = 0; c < NUM_CH; c++) begin
                    kcnt[c] = 0; rdy_cnt[c] = 0;
                end
            end else begin
                if (busy) begin
                    if (dly == 0) begin
                        adc_done = 1'b1;
                        adc_code = DATA_W'(gen(ch_l, kcnt[ch_l]));
                        kcnt[ch_l]++;
                        busy = 1'b0;
                    end else begin
                        dly--;
                    end
                end
                if (adc_start) begin
                    if (busy) overlap_err++;
                    busy = 1'b1;
                    ch_l = int'(adc_ch);
                    dly  = mdl_dly;
                    if (nstart < 64) begin
                        seq_log[nstart]   = int'(adc_ch);
                        start_cyc[nstart] = cyc;
                    end
                    nstart++;
                end
                for (int c = 0; c < NUM_CH; c++) begin
                    if (data_rdy[c]) begin
                        if (rdy_cnt[c] == 0) rdy_first[c] = data_out[c*DATA_W +: DATA_W];
                        rdy_cnt[c]++;
                    end
                end
                if (adc_sample) hi++;
                else if (hi != 0) begin
                    last_hi = hi; hi = 0;
                end
            end
        end
    end

    task automatic finish_sim();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_sim();
    end

    task automatic run_cfg(input logic [2:0] en, input logic [2:0] filt,
                           input int acq, input int per);
        @(negedge clk);
        cfg_ch_en = '0;
        mdl_clear = 1'b1;
        repeat (4) @(negedge clk);
        mdl_clear = 1'b0;
        @(negedge clk);
        cfg_acq_len = ACQ_W'(acq);
        cfg_period  = PER_W'(per);
        cfg_filter  = filt;
        cfg_ch_en   = en;
    endtask

    task automatic wait_all_rdy(input logic [2:0] en);
        bit done;
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk);
            done = 1'b1;
            for (int c = 0; c < NUM_CH; c++) if (en[c] && rdy_cnt[c] == 0) done = 1'b0;
            if (done) break;
        end
    endtask

    task automatic check_order(input logic [2:0] en, input string req);
        int lst [NUM_CH];
        int n_en, bad, lim;
        n_en = 0; bad = 0;
        for (int c = 0; c < NUM_CH; c++) if (en[c]) begin lst[n_en] = c; n_en++; end
        lim = (nstart < 64) ? nstart : 64;
        for (int i = 0; i < lim; i++) if (seq_log[i] != lst[i % n_en]) bad++;
        chk(bad == 0 && lim >= n_en, req, bad, 0);
    endtask

    initial begin
        logic [2:0] en, filt;
        int acq, per, n, ex;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(data_out == '0, "R1 data_out", data_out, 0);
        chk(data_rdy == '0 && adc_start == 1'b0 && adc_sample == 1'b0, "R1 control", {data_rdy, adc_start, adc_sample}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(data_out == '0, "R1 after release", data_out, 0);

        // table of configurations
        for (int v = 0; v < 6; v++) begin
            {en, filt} = {VEC[v][17:15], VEC[v][14:12]};
            acq = int'(VEC[v][11:4]);
            per = int'(VEC[v][3:0]);
            run_cfg(en, filt, acq, per);
            wait_all_rdy(en);
            n = filt[2] ? (1 << (int'(filt[1:0]) + 1)) : 1;
            for (int c = 0; c < NUM_CH; c++) begin
                if (en[c]) begin
                    ex = exp_avg(c, n);
                    // R6/R7 value, R10 slice position
                    chk(int'(rdy_first[c]) == ex, filt[2] ? "R7 average R10" : "R6 single R10", rdy_first[c], ex);
                end else begin
                    chk(rdy_cnt[c] == 0, "R4 disabled channel silent", rdy_cnt[c], 0);
                end
            end
            check_order(en, "R4 ascending order");
            chk(last_hi == acq + 1, "R2 acquire length", last_hi, acq + 1);
        end

        // R3: period spacing, one channel
        run_cfg(3'b001, 3'b000, 3, 2);
        for (int t = 0; t < 5000 && nstart < 3; t++) @(negedge clk);
        chk(start_cyc[2] - start_cyc[1] == UNIT * 3, "R3 period", start_cyc[2] - start_cyc[1], UNIT * 3);

        // R6: every sample updates when filter off
        for (int t = 0; t < 5000 && kcnt[0] < 5; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(rdy_cnt[0] == kcnt[0], "R6 update per sample", rdy_cnt[0], kcnt[0]);

        // R5: rounds longer than the period
        run_cfg(3'b111, 3'b000, 30, 0);
        repeat (1000) @(negedge clk);
        chk(overlap_err == 0, "R5 no overlapping request", overlap_err, 0);
        chk(rdy_cnt[2] >= 3, "R5 rounds continue", rdy_cnt[2], 3);
        check_order(3'b111, "R5 R4 order under overrun");

        // R9: clear in the middle of a 16-sample average
        run_cfg(3'b001, 3'b111, 3, 0);
        for (int t = 0; t < 5000 && kcnt[0] < 5; t++) @(negedge clk);
        @(negedge clk);
        cfg_ch_en = '0;
        mdl_clear = 1'b1;
        repeat (2) @(negedge clk);
        mdl_clear = 1'b0;
        repeat (UNIT * 2) @(negedge clk);
        chk(nstart == 0 && adc_sample == 1'b0, "R9 idle while cleared", nstart, 0);
        cfg_ch_en = 3'b001;
        wait_all_rdy(3'b001);
        chk(int'(rdy_first[0]) == exp_avg(0, 16), "R9 fresh average", rdy_first[0], exp_avg(0, 16));
        chk(rdy_cnt[0] == 1, "R8 single update", rdy_cnt[0], 1);

        finish_sim();
    end
endmodule